// File: doc/BRIEF.md
# Smart Card Character Transmitter with Status Flags

This block drives the transmit line of a half-duplex smart card serial port and keeps the three status flags that software and a DMA engine use to pace transmission. A character is ten bits long: a low start bit, eight data bits sent least significant bit first, then an even parity bit. The bit timing comes from a half-etu tick that arrives as a one-cycle strobe, so every bit lasts two ticks.

After the tenth bit the block listens to the card line in the middle of the following etu. A card that saw a parity error pulls the line low there, and that low level sets the error flag. When no error is seen and nothing is waiting in the data register, the end-of-transmission flag sets after a guard delay: 2.5 etu in normal guard mode and 1.0 etu in short guard mode. A character written into the data register during that delay cancels the pending set and is sent as soon as the delay ends.

Both status flags that software clears use a read-one-then-write-zero protocol. A separate halt input stands for the standby and module-stop states and returns every flag to its initial value.

Top module: `sc_tx_status`

## Requirements
- R1: After reset the error flag is 0, the end flag is 1, the empty flag is 1 and the line is high.
- R2: A character is sent as start bit 0, data bits 0 to 7 in that order, then a parity bit that makes the count of ones over data and parity even. Each bit lasts two half ticks and the line is high whenever no character is being sent.
- R3: When transmit is enabled, the transmitter is idle and the empty flag is 0, the character starts on the next clock edge and the empty flag returns to 1 at that same edge.
- R4: The line input is sampled at the first half tick after the tenth bit ends. A low level there sets the error flag at that edge.
- R5: The error flag clears only when a status write with error bit value 0 follows a status read that returned the error flag as 1, with no status write in between. A status write with value 1, or a write of 0 without that read, leaves the flag unchanged.
- R6: Clearing transmit enable leaves the error flag unchanged.
- R7: The end flag sets one edge after transmit enable is 0 while the error flag is 0, and it does not set from transmit enable being 0 while the error flag is 1.
- R8: With guard mode 0 the end flag sets at the fifth half tick after the tenth bit ends, when the empty flag is 1 and no error was sampled, and it is still 0 at the fourth.
- R9: With guard mode 1 the end flag sets at the second half tick after the tenth bit ends, under the same conditions, and it is still 0 at the first.
- R10: A sampled error signal prevents the end flag from setting after that character.
- R11: A status write with empty bit value 0, after a status read that returned the empty flag as 1, clears the empty and end flags. A DMA data write loads the data register and clears both flags at once.
- R12: A character loaded during the guard delay is not started before the delay ends, keeps the end flag at 0 when the delay ends, and is then sent normally.
- R13: Asserting halt clears the error flag, sets the end and empty flags and returns the line to high at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Standby or module-stop state |
| half_tick_i | input | 1 | One-cycle strobe every half etu |
| tx_en_i | input | 1 | Transmit enable |
| guard_i | input | 1 | Guard mode: 0 gives 2.5 etu, 1 gives 1.0 etu |
| cpu_data_wr_i | input | 1 | Processor write to the data register |
| dma_data_wr_i | input | 1 | DMA write to the data register |
| data_i | input | 8 | Write data for the data register |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| wr_err_i | input | 1 | Written value of the error flag |
| wr_empty_i | input | 1 | Written value of the empty flag |
| line_i | input | 1 | Card line level as seen by the port |
| line_o | output | 1 | Transmit line level |
| err_o | output | 1 | Error signal status flag |
| tend_o | output | 1 | Transmission end flag |
| empty_o | output | 1 | Data register empty flag |

## Verification
The hardest situation to reach is the one in R12: a second character has to arrive inside the few half ticks between the error sample and the end of the guard delay. From the ports this only works if the stimulus knows which half tick the transmitter is on. The bench monitor therefore counts the half ticks consumed since the falling start edge, and the driver waits for the count that lies inside the delay before it issues the DMA write. The same count places the low error pulse on the line input exactly around the sampling tick.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  parameter int unsigned SC_DATA_W      = 8;
  parameter int unsigned SC_GUARD0_HALF = 5;  // 2.5 etu in half ticks
  parameter int unsigned SC_GUARD1_HALF = 2;  // 1.0 etu in half ticks

  localparam int unsigned SC_FRAME_BITS = SC_DATA_W + 2;
  localparam int unsigned SC_N_FLAGS    = 2;
  localparam int unsigned SC_FLAG_ERR   = 0;
  localparam int unsigned SC_FLAG_EMPTY = 1;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SEND  = 2'd1,
    SQ_GUARD = 2'd2
  } sq_state_t;

  // Even parity over the data bits
  function automatic logic even_par(input logic [SC_DATA_W-1:0] d);
    return ^d;
  endfunction

  // Frame image, bit 0 leaves first: start, data LSB first, parity
  function automatic logic [SC_FRAME_BITS-1:0] frame_of(input logic [SC_DATA_W-1:0] d);
    return {even_par(d), d, 1'b0};
  endfunction

  // Guard delay length in half ticks
  function automatic int unsigned guard_half(input logic gm);
    return gm ? SC_GUARD1_HALF : SC_GUARD0_HALF;
  endfunction

endpackage

// File: rtl/sc_flag_arm.sv
module sc_flag_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic flag_i,
  output logic clr_ok_o
);

  logic armed_q;

  // Armed by a read that returns 1; any write or halt disarms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (halt_i || wr_i) begin
      armed_q <= 1'b0;
    end else if (rd_i && flag_i) begin
      armed_q <= 1'b1;
    end
  end

  assign clr_ok_o = wr_i && !wr_val_i && armed_q;

endmodule

// File: rtl/sc_frame_seq.sv
module sc_frame_seq
  import sc_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = SC_DATA_W,
  parameter int unsigned G0_HALF = SC_GUARD0_HALF,
  parameter int unsigned G1_HALF = SC_GUARD1_HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              tx_en_i,
  input  logic              half_tick_i,
  input  logic              guard_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              err_evt_o,
  output logic              done_evt_o
);

  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned HALF_MAX   = 2 * FRAME_BITS;
  localparam int unsigned CW         = $clog2(HALF_MAX + 1);
  localparam int unsigned GMAX       = (G0_HALF > G1_HALF) ? G0_HALF : G1_HALF;
  localparam int unsigned GW         = $clog2(GMAX + 1);
  localparam logic [CW-1:0] HLAST    = CW'(HALF_MAX - 1);
  localparam logic [GW-1:0] G0LAST   = GW'(G0_HALF - 1);
  localparam logic [GW-1:0] G1LAST   = GW'(G1_HALF - 1);

  sq_state_t             state_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [CW-1:0]         hcnt_q;
  logic [GW-1:0]         gcnt_q;
  logic                  gm_q;
  logic                  sample_evt;
  logic [GW-1:0]         glast;

  assign glast = gm_q ? G1LAST : G0LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      frame_q <= '1;
      hcnt_q  <= '0;
      gcnt_q  <= '0;
      gm_q    <= 1'b0;
    end else if (halt_i || !tx_en_i) begin
      state_q <= SQ_IDLE;
      frame_q <= '1;
      hcnt_q  <= '0;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            frame_q <= {1'b1, frame_of(data_i)} [FRAME_BITS-1:0];
            hcnt_q  <= '0;
            gm_q    <= guard_i;
            state_q <= SQ_SEND;
          end
        end
        SQ_SEND: begin
          if (half_tick_i) begin
            if (hcnt_q == HLAST) begin
              state_q <= SQ_GUARD;
              gcnt_q  <= '0;
              frame_q <= '1;
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
              if (hcnt_q[0]) begin
                frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
              end
            end
          end
        end
        SQ_GUARD: begin
          if (half_tick_i) begin
            if (gcnt_q == glast) begin
              state_q <= SQ_IDLE;
            end else begin
              gcnt_q <= gcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign line_o     = (state_q == SQ_SEND) ? frame_q[0] : 1'b1;
  assign busy_o     = (state_q != SQ_IDLE);
  assign sample_evt = (state_q == SQ_GUARD) && half_tick_i && (gcnt_q == '0)
                      && tx_en_i && !halt_i;
  assign err_evt_o  = sample_evt && !line_i;
  assign done_evt_o = (state_q == SQ_GUARD) && half_tick_i && (gcnt_q == glast)
                      && tx_en_i && !halt_i;

endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status
  import sc_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = SC_DATA_W,
  parameter int unsigned G0_HALF = SC_GUARD0_HALF,
  parameter int unsigned G1_HALF = SC_GUARD1_HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              half_tick_i,
  input  logic              tx_en_i,
  input  logic              guard_i,
  input  logic              cpu_data_wr_i,
  input  logic              dma_data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic              wr_err_i,
  input  logic              wr_empty_i,
  input  logic              line_i,
  output logic              line_o,
  output logic              err_o,
  output logic              tend_o,
  output logic              empty_o
);

  logic [DATA_W-1:0]     data_q;
  logic                  err_q;
  logic                  tend_q;
  logic                  empty_q;

  // Named internal events, visible to the checker
  logic                  load_evt;
  logic                  err_evt;
  logic                  done_evt;
  logic                  tend_set;
  logic                  tend_clr;
  logic                  seq_busy;

  logic [SC_N_FLAGS-1:0] arm_flag;
  logic [SC_N_FLAGS-1:0] arm_wval;
  logic [SC_N_FLAGS-1:0] arm_clr;

  assign arm_flag[SC_FLAG_ERR]   = err_q;
  assign arm_flag[SC_FLAG_EMPTY] = empty_q;
  assign arm_wval[SC_FLAG_ERR]   = wr_err_i;
  assign arm_wval[SC_FLAG_EMPTY] = wr_empty_i;

  for (genvar gi = 0; gi < SC_N_FLAGS; gi++) begin : g_arm
    sc_flag_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .halt_i   (halt_i),
      .rd_i     (stat_rd_i),
      .wr_i     (stat_wr_i),
      .wr_val_i (arm_wval[gi]),
      .flag_i   (arm_flag[gi]),
      .clr_ok_o (arm_clr[gi])
    );
  end

  sc_frame_seq #(
    .DATA_W  (DATA_W),
    .G0_HALF (G0_HALF),
    .G1_HALF (G1_HALF)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_i      (halt_i),
    .tx_en_i     (tx_en_i),
    .half_tick_i (half_tick_i),
    .guard_i     (guard_i),
    .start_i     (load_evt),
    .data_i      (data_q),
    .line_i      (line_i),
    .line_o      (line_o),
    .busy_o      (seq_busy),
    .err_evt_o   (err_evt),
    .done_evt_o  (done_evt)
  );

  assign load_evt = !seq_busy && tx_en_i && !empty_q && !halt_i;
  assign tend_set = done_evt && empty_q && !err_q && !err_evt;
  assign tend_clr = dma_data_wr_i || arm_clr[SC_FLAG_EMPTY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cpu_data_wr_i || dma_data_wr_i) begin
      data_q <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (halt_i) begin
      err_q <= 1'b0;
    end else if (err_evt) begin
      err_q <= 1'b1;
    end else if (arm_clr[SC_FLAG_ERR]) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
    end else if (halt_i || load_evt) begin
      empty_q <= 1'b1;
    end else if (tend_clr) begin
      empty_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
    end else if (halt_i) begin
      tend_q <= 1'b1;
    end else if (!tx_en_i && !err_q) begin
      tend_q <= 1'b1;
    end else if (tend_set) begin
      tend_q <= 1'b1;
    end else if (tend_clr) begin
      tend_q <= 1'b0;
    end
  end

  assign err_o   = err_q;
  assign tend_o  = tend_q;
  assign empty_o = empty_q;

endmodule

// File: rtl/sc_tx_status_chk.sv
module sc_tx_status_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_i,
  input logic tx_en_i,
  input logic stat_wr_i,
  input logic wr_err_i,
  input logic dma_data_wr_i,
  input logic line_o,
  input logic err_o,
  input logic tend_o,
  input logic empty_o,
  input logic load_evt,
  input logic seq_busy
);

  // R13: halt returns all flags to their initial values
  a_r13_halt_state: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (!err_o && tend_o && empty_o));

  // R2: line idles high whenever no character is in flight
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> line_o);

  // R3: starting a character empties the data register
  a_r3_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> empty_o);

  // R5: error flag falls only through a status write of 0 or halt
  a_r5_err_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past((stat_wr_i && !wr_err_i) || halt_i));

  // R6: outside writes, halt and transmission the error flag holds
  a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_i && !halt_i && !seq_busy) |=> $stable(err_o));

  // R7: transmit disabled with no error forces the end flag
  a_r7_forced_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_i && !err_o && !halt_i) |=> tend_o);

  // R10: a set error flag blocks a rise of the end flag
  a_r10_no_end_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !halt_i) |=> !$rose(tend_o));

  // R11: end flag falls only through a DMA write or a status write
  a_r11_end_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tend_o) |-> $past(dma_data_wr_i || stat_wr_i));

endmodule

bind sc_tx_status sc_tx_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_i        (halt_i),
  .tx_en_i       (tx_en_i),
  .stat_wr_i     (stat_wr_i),
  .wr_err_i      (wr_err_i),
  .dma_data_wr_i (dma_data_wr_i),
  .line_o        (line_o),
  .err_o         (err_o),
  .tend_o        (tend_o),
  .empty_o       (empty_o),
  .load_evt      (load_evt),
  .seq_busy      (seq_busy)
);

// File: tb/sc_tx_status_tb_top.sv
module sc_tx_status_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_i = 1'b0;
  logic       half_tick_i = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       guard_i = 1'b0;
  logic       cpu_data_wr_i = 1'b0;
  logic       dma_data_wr_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       stat_rd_i = 1'b0;
  logic       stat_wr_i = 1'b0;
  logic       wr_err_i = 1'b1;
  logic       wr_empty_i = 1'b1;
  logic       line_i = 1'b1;
  logic       line_o, err_o, tend_o, empty_o;

  always #4 clk = ~clk;  // 125 MHz

  sc_tx_status dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .half_tick_i(half_tick_i),
    .tx_en_i(tx_en_i), .guard_i(guard_i), .cpu_data_wr_i(cpu_data_wr_i),
    .dma_data_wr_i(dma_data_wr_i), .data_i(data_i), .stat_rd_i(stat_rd_i),
    .stat_wr_i(stat_wr_i), .wr_err_i(wr_err_i), .wr_empty_i(wr_empty_i),
    .line_i(line_i), .line_o(line_o), .err_o(err_o), .tend_o(tend_o),
    .empty_o(empty_o)
  );

  typedef struct {
    logic [7:0] data;
    logic       guard;
    logic       inject;
    logic       exp_end;
    int         end_req;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_err = 0;
  int items_done = 0;
  bit finished = 1'b0;

  // Monitor state
  bit    mon_act = 1'b0;
  int    mon_n = 0;
  item_t cur;
  logic  prev_line = 1'b1;
  int    ht_cnt = 0;
  int    cyc = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ref_bits(logic [7:0] d);
    logic p = 1'b0;
    for (int i = 0; i < 8; i++) p = p ^ d[i];
    return {p, d, 1'b0};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Half-tick source and scoreboard monitor share one negedge process
  always @(negedge clk) begin
    bit consumed;
    int dly;
    int bi;
    logic [9:0] bits;
    consumed = half_tick_i;
    if (rst_n) begin
      if (!mon_act) begin
        if (prev_line && !line_o) begin
          mon_act = 1'b1;
          mon_n = 0;
          if (exp_q.size() == 0) begin
            check("R2 unexpected start", 1, 0);
            cur = '{8'h00, 1'b0, 1'b0, 1'b0, 2};
          end else begin
            cur = exp_q.pop_front();
          end
        end
      end else if (consumed) begin
        mon_n++;
        bits = ref_bits(cur.data);
        dly = cur.guard ? 2 : 5;
        if (mon_n <= 19 && (mon_n % 2) == 1) begin
          bi = (mon_n - 1) / 2;
          check($sformatf("R2 bit%0d of %02h", bi, cur.data), int'(line_o), int'(bits[bi]));
        end
        if (mon_n == 20 && cur.inject) line_i = 1'b0;
        if (mon_n == 21) begin
          line_i = 1'b1;
          check("R4 error sample", int'(err_o), int'(cur.inject));
        end
        if (mon_n == 20 + dly - 1)
          check(cur.guard ? "R9 early" : "R8 early", int'(tend_o), 0);
        if (mon_n == 20 + dly) begin
          check($sformatf("R%0d end flag", cur.end_req), int'(tend_o), int'(cur.exp_end));
          mon_act = 1'b0;
          items_done++;
        end
      end
      prev_line = line_o;
      half_tick_i = (ht_cnt == 3);
      ht_cnt = (ht_cnt + 1) % 4;
    end
  end

  // Watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000 && !finished) begin
      finished = 1'b1;
      check("watchdog", 1, 0);
      report();
    end
  end

  task automatic cpu_send(logic [7:0] d, logic g, logic inj, logic ee, int rq);
    exp_q.push_back('{d, g, inj, ee, rq});
    @(negedge clk); data_i = d; guard_i = g; cpu_data_wr_i = 1'b1;
    @(negedge clk); cpu_data_wr_i = 1'b0; stat_rd_i = 1'b1;
    @(negedge clk); stat_rd_i = 1'b0; stat_wr_i = 1'b1; wr_empty_i = 1'b0; wr_err_i = 1'b1;
    @(negedge clk); stat_wr_i = 1'b0; wr_empty_i = 1'b1;
    check("R11 cpu clears empty", int'(empty_o), 0);
    check("R11 cpu clears end", int'(tend_o), 0);
    @(negedge clk);
    check("R3 load sets empty", int'(empty_o), 1);
  endtask

  task automatic dma_send(logic [7:0] d, logic g, logic inj, logic ee, int rq);
    exp_q.push_back('{d, g, inj, ee, rq});
    @(negedge clk); data_i = d; guard_i = g; dma_data_wr_i = 1'b1;
    @(negedge clk); dma_data_wr_i = 1'b0;
    check("R11 dma clears empty", int'(empty_o), 0);
    check("R11 dma clears end", int'(tend_o), 0);
  endtask

  task automatic wait_items(int k);
    wait (items_done >= k);
    @(negedge clk);
  endtask

  task automatic stat_write(logic we, logic wm);
    @(negedge clk); stat_wr_i = 1'b1; wr_err_i = we; wr_empty_i = wm;
    @(negedge clk); stat_wr_i = 1'b0; wr_err_i = 1'b1; wr_empty_i = 1'b1;
  endtask

  task automatic stat_read();
    @(negedge clk); stat_rd_i = 1'b1;
    @(negedge clk); stat_rd_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 err", int'(err_o), 0);
    check("R1 end", int'(tend_o), 1);
    check("R1 empty", int'(empty_o), 1);
    check("R1 line", int'(line_o), 1);
    tx_en_i = 1'b1;

    // Normal guard, processor path (R8)
    cpu_send(8'hA5, 1'b0, 1'b0, 1'b1, 8);
    wait_items(1);
    // Short guard, DMA path (R9)
    dma_send(8'h01, 1'b1, 1'b0, 1'b1, 9);
    wait_items(2);
    // Error signal from the card (R4, R10)
    dma_send(8'h3C, 1'b0, 1'b1, 1'b0, 10);
    wait_items(3);
    check("R4 err held", int'(err_o), 1);

    // R6: disabling transmit keeps the error flag; R7 blocked by error
    @(negedge clk); tx_en_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 err after disable", int'(err_o), 1);
    check("R7 no forced end with err", int'(tend_o), 0);

    // R5: write 0 without a preceding read
    stat_write(1'b0, 1'b1);
    check("R5 unarmed write 0", int'(err_o), 1);
    // read, then write 1, then write 0: the write 1 disarms
    stat_read();
    stat_write(1'b1, 1'b1);
    check("R5 write 1", int'(err_o), 1);
    stat_write(1'b0, 1'b1);
    check("R5 disarmed write 0", int'(err_o), 1);
    // proper read then write 0
    stat_read();
    @(negedge clk); stat_wr_i = 1'b1; wr_err_i = 1'b0;
    @(negedge clk); stat_wr_i = 1'b0; wr_err_i = 1'b1;
    check("R5 armed clear", int'(err_o), 0);
    check("R7 not yet", int'(tend_o), 0);
    @(negedge clk);
    check("R7 forced end", int'(tend_o), 1);

    // R12: second character written inside the guard delay
    tx_en_i = 1'b1;
    dma_send(8'hFF, 1'b0, 1'b0, 1'b0, 12);
    wait (mon_act && mon_n == 22);
    exp_q.push_back('{8'h00, 1'b0, 1'b0, 1'b1, 8});
    @(negedge clk); data_i = 8'h00; dma_data_wr_i = 1'b1;
    @(negedge clk); dma_data_wr_i = 1'b0;
    check("R12 held during delay", int'(empty_o), 0);
    wait_items(5);

    // R13: halt after an error in short guard mode
    dma_send(8'h80, 1'b1, 1'b1, 1'b0, 10);
    wait_items(6);
    check("R4 err short guard", int'(err_o), 1);
    @(negedge clk); halt_i = 1'b1;
    @(negedge clk); halt_i = 1'b0;
    check("R13 err", int'(err_o), 0);
    check("R13 end", int'(tend_o), 1);
    check("R13 empty", int'(empty_o), 1);
    check("R13 line", int'(line_o), 1);

    check("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    report();
  end

endmodule